// File: doc/BRIEF.md
# Core Interrupt Timer

This block is the countdown timer of a per-core interrupt controller. Software programs a 32-bit timer entry register and a start-count register through a simple register port. Writing the start count loads the counter, which then counts down once per cycle in which the tick enable is high. When the count runs from one to zero, the timer has expired and the block consults the timer entry.

If the entry's mask bit is clear, expiry raises a one-cycle request that carries the entry's vector, delivery mode and trigger level. The periodic bit decides what happens to the counter. When it is set, the counter reloads from the stored start count and runs again. When it is clear, the counter stays at zero until software writes the start count again. The mask only suppresses the request; the reload still happens.

The request output is a plain single-cycle pulse with no ready input. The consumer must accept it in the cycle it is shown, because there is no back-pressure and no queueing.

Top module: `core_irq_timer`

## Requirements
- R1: After reset the counter and the start count read 0, the entry reads 0x0001_0000 (only the mask bit set), and no request is raised.
- R2: Register addresses are 0 = entry, 1 = start count, 2 = current count (read only), 3 = spare. In the entry, bits 7:0 are the vector, bits 10:8 the delivery mode, bit 13 the polarity, bit 15 the trigger level, bit 16 the mask and bit 17 periodic mode. Bits 12 and 14 and all other bits read as zero whatever is written.
- R3: A write to the start count loads the counter with the written value on the same clock edge. The counter then decreases by exactly one on each edge with tick_en high and holds while tick_en is low.
- R4: When the counter runs from 1 to 0 and the mask bit is clear, req_valid is high for the one cycle after that edge, with req_vector, req_mode and req_level equal to entry bits 7:0, 10:8 and 15.
- R5: When the mask bit is set, expiry raises no request, but the counter still reloads or stops according to the periodic bit.
- R6: With the periodic bit set, the expiry edge loads the counter from the stored start count, so requests repeat every start-count ticks.
- R7: With the periodic bit clear, the counter stays at 0 after expiry and no further request follows.
- R8: Writing zero to the start count stops the timer, and no request is raised.
- R9: A start-count write in the same cycle as an expiry wins: the counter takes the written value and no request is raised.
- R10: Writes to the spare address and to the current-count address change no register; the spare address reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Countdown enable for this cycle |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| req_valid | output | 1 | One-cycle interrupt request pulse |
| req_vector | output | 8 | Vector of the request |
| req_mode | output | 3 | Delivery mode of the request |
| req_level | output | 1 | Trigger level of the request |

## Verification
The bench samples req_valid on every cycle of a countdown. A timer that expires one tick early or late, or that fires on reaching 1 instead of 0, shows up as a pulse in the wrong cycle. A masked periodic run checks that the reload still happens with the request suppressed; a design that ties the reload to the mask would leave the counter at zero. A start-count write that lands on the expiry edge must win and raise nothing, which catches a design that gives the countdown priority or leaks a stale pulse. The entry readback after an all-ones write exposes any status bit that software could wrongly set.

// File: rtl/irq_timer_pkg.sv
package irq_timer_pkg;
  localparam int DATA_W = 32;
  localparam int VEC_W  = 8;
  localparam int MODE_W = 3;

  typedef enum logic [1:0] {
    ADDR_ENTRY = 2'd0,
    ADDR_START = 2'd1,
    ADDR_COUNT = 2'd2,
    ADDR_SPARE = 2'd3
  } reg_addr_e;

  // Timer entry layout: field positions are software-visible.
  typedef struct packed {
    logic [13:0]       rsvd_hi;
    logic              periodic;
    logic              mask;
    logic              level;
    logic              rem_flag;
    logic              polarity;
    logic              busy_flag;
    logic              rsvd_11;
    logic [MODE_W-1:0] mode;
    logic [VEC_W-1:0]  vector;
  } tmr_entry_t;

  localparam logic [DATA_W-1:0] ENTRY_WR_MASK = 32'h0003_A7FF;
  localparam logic [DATA_W-1:0] ENTRY_RST     = 32'h0001_0000;
endpackage

// File: rtl/itmr_cfg_regs.sv
module itmr_cfg_regs
  import irq_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_entry_i,
  input  logic              wr_start_i,
  input  logic [DATA_W-1:0] wdata_i,
  output tmr_entry_t        entry_o,
  output logic [CNT_W-1:0]  start_o
);
  tmr_entry_t       entry_q;
  logic [CNT_W-1:0] start_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entry_q <= tmr_entry_t'(ENTRY_RST);
      start_q <= '0;
    end else begin
      if (wr_entry_i) entry_q <= tmr_entry_t'(wdata_i & ENTRY_WR_MASK);
      if (wr_start_i) start_q <= wdata_i[CNT_W-1:0];
    end
  end

  assign entry_o = entry_q;
  assign start_o = start_q;

  // R2: read-only status bits never become set by a write
  p_status_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_entry_i |=> (!entry_q.busy_flag && !entry_q.rem_flag));
  // R10: without a write strobe the entry keeps its value
  p_entry_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_entry_i |=> $stable(entry_q));
endmodule

// File: rtl/itmr_counter.sv
module itmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  input  logic             periodic_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  // A load in the same cycle takes priority and suppresses expiry.
  assign expire_o = !load_i && tick_i && (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (tick_i && cnt_q != '0) begin
      if (cnt_q == ONE) cnt_q <= periodic_i ? reload_i : '0;
      else              cnt_q <= cnt_q - ONE;
    end
  end

  assign cnt_o = cnt_q;

  p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && tick_i && cnt_q > ONE) |=> cnt_q == $past(cnt_q) - ONE);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !tick_i) |=> $stable(cnt_q));
  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && periodic_i) |=> cnt_q == $past(reload_i));
  p_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && !periodic_i) |=> cnt_q == '0);
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q == '0) |=> cnt_q == '0);
endmodule

// File: rtl/itmr_req_gen.sv
module itmr_req_gen
  import irq_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              expire_i,
  input  logic              mask_i,
  input  logic [VEC_W-1:0]  vector_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              level_i,
  output logic              req_valid_o,
  output logic [VEC_W-1:0]  req_vector_o,
  output logic [MODE_W-1:0] req_mode_o,
  output logic              req_level_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid_o  <= 1'b0;
      req_vector_o <= '0;
      req_mode_o   <= '0;
      req_level_o  <= 1'b0;
    end else begin
      req_valid_o <= expire_i && !mask_i;
      if (expire_i) begin
        req_vector_o <= vector_i;
        req_mode_o   <= mode_i;
        req_level_o  <= level_i;
      end
    end
  end

  p_req_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_i && !mask_i) |=> req_valid_o && req_vector_o == $past(vector_i));
  p_masked_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!expire_i || mask_i) |=> !req_valid_o);
endmodule

// File: rtl/core_irq_timer.sv
module core_irq_timer
  import irq_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              req_valid,
  output logic [VEC_W-1:0]  req_vector,
  output logic [MODE_W-1:0] req_mode,
  output logic              req_level
);
  tmr_entry_t       entry;
  logic [CNT_W-1:0] start_cnt;
  logic [CNT_W-1:0] cur_cnt;
  logic             expire;
  logic             wr_entry, wr_start;

  assign wr_entry = reg_wr_en && (reg_addr_e'(reg_addr) == ADDR_ENTRY);
  assign wr_start = reg_wr_en && (reg_addr_e'(reg_addr) == ADDR_START);

  itmr_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_entry_i(wr_entry), .wr_start_i(wr_start),
    .wdata_i(reg_wdata), .entry_o(entry), .start_o(start_cnt)
  );

  itmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_i(wr_start),
    .load_val_i(reg_wdata[CNT_W-1:0]), .tick_i(tick_en),
    .periodic_i(entry.periodic), .reload_i(start_cnt),
    .cnt_o(cur_cnt), .expire_o(expire)
  );

  itmr_req_gen u_req (
    .clk(clk), .rst_n(rst_n), .expire_i(expire), .mask_i(entry.mask),
    .vector_i(entry.vector), .mode_i(entry.mode), .level_i(entry.level),
    .req_valid_o(req_valid), .req_vector_o(req_vector),
    .req_mode_o(req_mode), .req_level_o(req_level)
  );

  always_comb begin
    case (reg_addr_e'(reg_addr))
      ADDR_ENTRY: reg_rdata = DATA_W'(entry);
      ADDR_START: reg_rdata = DATA_W'(start_cnt);
      ADDR_COUNT: reg_rdata = DATA_W'(cur_cnt);
      default:    reg_rdata = '0;
    endcase
  end

  // R9: a start-count write never coincides with a raised request next cycle
  p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> !req_valid);
endmodule

// File: tb/test_core_irq_timer.sv
module test_core_irq_timer;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_addr = 2'd2;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid;
  logic [7:0]  req_vector;
  logic [2:0]  req_mode;
  logic        req_level;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  core_irq_timer i_core_irq_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr_en(reg_wr_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req_valid(req_valid), .req_vector(req_vector), .req_mode(req_mode),
    .req_level(req_level)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    step();
    reg_wr_en = 1'b0; reg_addr = 2'd2;
  endtask

  function automatic logic [31:0] rd(logic [1:0] a);
    reg_addr = a;
    return reg_rdata;
  endfunction

  task automatic read_chk(string req, logic [1:0] a, logic [31:0] exp);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
    reg_addr = 2'd2;
  endtask

  // Count n ticks after a load; a pulse is expected only after the last.
  task automatic run_expect(string req, int n, logic pulse);
    int bad = 0;
    for (int i = 1; i < n; i++) begin
      step();
      if (req_valid) bad++;
    end
    check({req, " early pulse"}, bad, 0);
    step();
    check({req, " pulse"}, req_valid, pulse);
  endtask

  task automatic t_reset();
    check("R1 req", req_valid, 0);
    read_chk("R1 count", 2'd2, 32'h0);
    read_chk("R1 start", 2'd1, 32'h0);
    read_chk("R1 entry", 2'd0, 32'h0001_0000);
  endtask

  task automatic t_entry_fields();
    wr(2'd0, 32'hFFFF_FFFF);
    read_chk("R2 writable bits", 2'd0, 32'h0003_A7FF);
    wr(2'd3, 32'h1234_5678);
    wr(2'd2, 32'h0000_0077);
    read_chk("R10 entry kept", 2'd0, 32'h0003_A7FF);
    read_chk("R10 spare reads 0", 2'd3, 32'h0);
    read_chk("R10 count kept", 2'd2, 32'h0);
  endtask

  task automatic t_count_hold();
    tick_en = 1'b0;
    wr(2'd0, 32'h0001_0000);
    wr(2'd1, 32'd6);
    read_chk("R3 loaded", 2'd2, 32'd6);
    step(); step(); step();
    read_chk("R3 hold", 2'd2, 32'd6);
    tick_en = 1'b1;
    step(); step();
    read_chk("R3 dec", 2'd2, 32'd4);
    tick_en = 1'b0;
    wr(2'd1, 32'd0);
  endtask

  task automatic t_oneshot();
    tick_en = 1'b1;
    wr(2'd0, 32'h0000_825A); // vec 0x5A, mode 2, level 1, unmasked, one-shot
    wr(2'd1, 32'd4);
    run_expect("R4", 4, 1'b1);
    check("R4 vector", req_vector, 8'h5A);
    check("R4 mode", req_mode, 3'd2);
    check("R4 level", req_level, 1'b1);
    step();
    check("R4 one cycle", req_valid, 0);
    read_chk("R7 stopped", 2'd2, 32'd0);
    begin
      int extra = 0;
      for (int i = 0; i < 8; i++) begin step(); if (req_valid) extra++; end
      check("R7 no repeat", extra, 0);
    end
  endtask

  task automatic t_periodic();
    tick_en = 1'b1;
    wr(2'd0, 32'h0002_0031 | 32'h0000_0400); // vec 0x31, mode 4, periodic
    wr(2'd1, 32'd3);
    run_expect("R6 first", 3, 1'b1);
    read_chk("R6 reloaded", 2'd2, 32'd3);
    run_expect("R6 second", 3, 1'b1);
    check("R6 vector", req_vector, 8'h31);
    check("R6 mode", req_mode, 3'd4);
    run_expect("R6 third", 3, 1'b1);
    wr(2'd1, 32'd0);
  endtask

  task automatic t_masked();
    tick_en = 1'b1;
    wr(2'd0, 32'h0003_0040); // masked, periodic
    wr(2'd1, 32'd3);
    run_expect("R5 masked", 3, 1'b0);
    read_chk("R5 reload despite mask", 2'd2, 32'd3);
    wr(2'd0, 32'h0001_0040); // masked one-shot
    run_expect("R5 masked oneshot", 3, 1'b0);
    read_chk("R5 stop", 2'd2, 32'd0);
  endtask

  task automatic t_stop_zero();
    tick_en = 1'b1;
    wr(2'd0, 32'h0000_0010);
    wr(2'd1, 32'd5);
    step(); step();
    wr(2'd1, 32'd0);
    read_chk("R8 count zero", 2'd2, 32'd0);
    begin
      int seen = 0;
      for (int i = 0; i < 10; i++) begin step(); if (req_valid) seen++; end
      check("R8 no request", seen, 0);
    end
  endtask

  task automatic t_collision();
    tick_en = 1'b1;
    wr(2'd0, 32'h0000_0020);
    wr(2'd1, 32'd2);
    step(); // count now 1, next edge would expire
    read_chk("R9 pre", 2'd2, 32'd1);
    wr(2'd1, 32'd5);
    check("R9 no request", req_valid, 0);
    read_chk("R9 count", 2'd2, 32'd5);
    run_expect("R9 later", 5, 1'b1);
    wr(2'd1, 32'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_entry_fields();
    t_count_hold();
    t_oneshot();
    t_periodic();
    t_masked();
    t_stop_zero();
    t_collision();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule